// File: doc/BRIEF.md
# Bank-Select and Pipeline-Flush Controller

This block is the part of a system coprocessor that owns the register-file bank selector. It holds an 8-bit bank number, and that number drives the bank-select lines of a multi-bank general-purpose register file directly. Software changes banks with a move-to-coprocessor operation aimed at the bank register number. It reads the current bank back with a move-from-coprocessor operation.

A bank write must not leave half-executed instructions that mix the old and new register sets. For that reason the write raises the same one-cycle pipeline flush used for traps. The restart address is the memory-stage address plus 4, so fetch resumes at the instruction that follows the write and no padding instructions are needed.

Hardware interrupts and software exceptions also flush, restart at the vector and force the bank to 0, which makes bank 0 the supervisory bank. The memory-stage address at that moment is captured as the return address. The bank number in use before the trap is lost. A return-from-interrupt flushes and restarts at the captured address.

Top module: `bank_ctl_top`

## Requirements
- R1: During and right after synchronous reset, `bank_sel_o` is 0, `flush_o` is 0, `restart_pc_o` is 0 and the captured return address is 0.
- R2: A move-to with `mt_regno_i` equal to 22 loads `mt_data_i[7:0]` into the bank register. The new value appears on `bank_sel_o` at the same clock edge on which `flush_o` rises.
- R3: For a flush caused by a bank write, `restart_pc_o` equals the `mem_pc_i` of the write cycle plus 4.
- R4: An interrupt (`irq_i`) or exception (`exc_i`) causes a flush with `restart_pc_o` equal to `vector_i`. It forces the bank register to 0, and the previous bank value is not retained anywhere.
- R5: An interrupt or exception captures `mem_pc_i` as the return address. A return-from-interrupt (`rfe_i`) causes a flush with `restart_pc_o` equal to that captured address.
- R6: Restart priority is: interrupt/exception first, then return-from-interrupt, then bank write. A bank write in the same cycle as an interrupt or exception is discarded, so the bank becomes 0. A bank write in the same cycle as a return still loads the bank, but the restart uses the captured address.
- R7: `flush_o` is high for exactly the one cycle after each cycle that holds an event. After a cycle with no event it is low.
- R8: A move-to with any register number other than 22 has no effect on `bank_sel_o` and raises no flush.
- R9: `mf_data_o` is combinational. Register number 22 returns the bank zero-extended, register number 14 returns the captured return address, and any other number returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_valid_i | input | 1 | Move-to-coprocessor strobe |
| mt_regno_i | input | 5 | Target register number of the move-to |
| mt_data_i | input | 32 | Move-to data |
| mf_regno_i | input | 5 | Register number to read |
| mf_data_o | output | 32 | Move-from read data |
| mem_pc_i | input | 32 | Address of the instruction in the memory stage |
| irq_i | input | 1 | Hardware interrupt taken |
| exc_i | input | 1 | Software exception taken |
| rfe_i | input | 1 | Return-from-interrupt strobe |
| vector_i | input | 32 | Trap vector address |
| flush_o | output | 1 | Pipeline flush pulse |
| restart_pc_o | output | 32 | Fetch restart address, valid while flush_o is high |
| bank_sel_o | output | 8 | Register-file bank select |

## Verification
The hardest situations to reach are coincident events. An interrupt can land in the same cycle as a bank write, and a return can coincide with a bank write. A return can also arrive after a chain of traps that each overwrote the captured address. Random stimulus raises each event line with moderate probability, so collisions occur often, and directed cycles force each collision once. A bench model tracks the bank and the return address independently and predicts every flush, restart address and read value.

// File: rtl/bank_ctl_pkg.sv
package bank_ctl_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BANK_W     = 8;
    localparam int REGNO_W    = 5;
    localparam int BANK_REGNO = 22;
    localparam int EPC_REGNO  = 14;
    localparam int PC_STEP    = 4;

    typedef enum logic [1:0] {
        FL_NONE   = 2'd0,
        FL_TRAP   = 2'd1,
        FL_RETURN = 2'd2,
        FL_BANK   = 2'd3
    } flush_cause_e;

    typedef struct packed {
        logic trap;
        logic ret;
        logic bank_wr;
    } flush_req_t;

    function automatic flush_cause_e pick_cause(flush_req_t req);
        if (req.trap)         return FL_TRAP;
        else if (req.ret)     return FL_RETURN;
        else if (req.bank_wr) return FL_BANK;
        else                  return FL_NONE;
    endfunction

endpackage

// File: rtl/bank_ctl_arb.sv
module bank_ctl_arb
    import bank_ctl_pkg::*;
(
    input  flush_req_t   req_i,
    output flush_cause_e cause_o
);

    always_comb begin
        cause_o = pick_cause(req_i);
    end

endmodule

// File: rtl/bank_ctl_epc.sv
module bank_ctl_epc #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] saved_o
);

    always_ff @(posedge clk) begin
        if (rst)            saved_o <= '0;
        else if (capture_i) saved_o <= pc_i;
    end

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> saved_o == $past(pc_i)); // R5
    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(saved_o)); // R5

endmodule

// File: rtl/bank_ctl_sel.sv
module bank_ctl_sel #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [BANK_W-1:0] data_i,
    output logic [BANK_W-1:0] bank_o
);

    always_ff @(posedge clk) begin
        if (rst)          bank_o <= '0;
        else if (clear_i) bank_o <= '0;
        else if (load_i)  bank_o <= data_i;
    end

    AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> bank_o == '0); // R4
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clear_i) |=> bank_o == $past(data_i)); // R2
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !clear_i) |=> $stable(bank_o)); // R8

endmodule

// File: rtl/bank_ctl_top.sv
module bank_ctl_top
    import bank_ctl_pkg::*;
#(
    parameter int P_ADDR_W     = ADDR_W,
    parameter int P_DATA_W     = DATA_W,
    parameter int P_BANK_W     = BANK_W,
    parameter int P_REGNO_W    = REGNO_W,
    parameter int P_BANK_REGNO = BANK_REGNO,
    parameter int P_EPC_REGNO  = EPC_REGNO
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mt_valid_i,
    input  logic [P_REGNO_W-1:0]  mt_regno_i,
    input  logic [P_DATA_W-1:0]   mt_data_i,
    input  logic [P_REGNO_W-1:0]  mf_regno_i,
    output logic [P_DATA_W-1:0]   mf_data_o,
    input  logic [P_ADDR_W-1:0]   mem_pc_i,
    input  logic                  irq_i,
    input  logic                  exc_i,
    input  logic                  rfe_i,
    input  logic [P_ADDR_W-1:0]   vector_i,
    output logic                  flush_o,
    output logic [P_ADDR_W-1:0]   restart_pc_o,
    output logic [P_BANK_W-1:0]   bank_sel_o
);

    localparam logic [P_REGNO_W-1:0] BANK_NUM = P_REGNO_W'(P_BANK_REGNO);
    localparam logic [P_REGNO_W-1:0] EPC_NUM  = P_REGNO_W'(P_EPC_REGNO);
    localparam logic [P_ADDR_W-1:0]  STEP     = P_ADDR_W'(PC_STEP);

    flush_req_t          req;
    flush_cause_e        cause;
    logic [P_ADDR_W-1:0] saved_pc;

    always_comb begin
        req.trap    = irq_i | exc_i;
        req.ret     = rfe_i;
        req.bank_wr = mt_valid_i && (mt_regno_i == BANK_NUM);
    end

    bank_ctl_arb u_arb (
        .req_i   (req),
        .cause_o (cause)
    );

    bank_ctl_epc #(.ADDR_W(P_ADDR_W)) u_epc (
        .clk       (clk),
        .rst       (rst),
        .capture_i (req.trap),
        .pc_i      (mem_pc_i),
        .saved_o   (saved_pc)
    );

    bank_ctl_sel #(.BANK_W(P_BANK_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .clear_i (req.trap),
        .load_i  (req.bank_wr),
        .data_i  (mt_data_i[P_BANK_W-1:0]),
        .bank_o  (bank_sel_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_o      <= 1'b0;
            restart_pc_o <= '0;
        end else begin
            flush_o <= (cause != FL_NONE);
            case (cause)
                FL_TRAP:   restart_pc_o <= vector_i;
                FL_RETURN: restart_pc_o <= saved_pc;
                FL_BANK:   restart_pc_o <= mem_pc_i + STEP;
                default:   restart_pc_o <= restart_pc_o;
            endcase
        end
    end

    always_comb begin
        if (mf_regno_i == BANK_NUM)     mf_data_o = P_DATA_W'(bank_sel_o);
        else if (mf_regno_i == EPC_NUM) mf_data_o = P_DATA_W'(saved_pc);
        else                            mf_data_o = '0;
    end

    AST_TRAP_RESTART: assert property (@(posedge clk) disable iff (rst)
        (irq_i || exc_i) |=> flush_o && restart_pc_o == $past(vector_i)); // R4
    AST_RETURN_RESTART: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && !irq_i && !exc_i) |=> flush_o && restart_pc_o == $past(saved_pc)); // R5
    AST_BANK_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mt_valid_i && mt_regno_i == BANK_NUM && !rfe_i && !irq_i && !exc_i)
        |=> flush_o && restart_pc_o == $past(mem_pc_i) + STEP); // R3
    AST_NO_SPURIOUS_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !(irq_i || exc_i || rfe_i || (mt_valid_i && mt_regno_i == BANK_NUM)) |=> !flush_o); // R7

endmodule

// File: tb/bank_ctl_top_tb.sv
module bank_ctl_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        mt_valid_i;
    logic [4:0]  mt_regno_i;
    logic [31:0] mt_data_i;
    logic [4:0]  mf_regno_i;
    logic [31:0] mf_data_o;
    logic [31:0] mem_pc_i;
    logic        irq_i, exc_i, rfe_i;
    logic [31:0] vector_i;
    logic        flush_o;
    logic [31:0] restart_pc_o;
    logic [7:0]  bank_sel_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [7:0]  m_bank;
    logic [31:0] m_saved;
    logic        m_flush;
    logic [31:0] m_restart;
    string       m_tag;

    always #2.5 clk = ~clk;

    bank_ctl_top u_dut (
        .clk(clk), .rst(rst),
        .mt_valid_i(mt_valid_i), .mt_regno_i(mt_regno_i), .mt_data_i(mt_data_i),
        .mf_regno_i(mf_regno_i), .mf_data_o(mf_data_o),
        .mem_pc_i(mem_pc_i), .irq_i(irq_i), .exc_i(exc_i), .rfe_i(rfe_i),
        .vector_i(vector_i), .flush_o(flush_o), .restart_pc_o(restart_pc_o),
        .bank_sel_o(bank_sel_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] read_model(logic [4:0] rn);
        if (rn == 5'd22)      return {24'd0, m_bank};
        else if (rn == 5'd14) return m_saved;
        else                  return 32'd0;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    task automatic idle();
        mt_valid_i = 0; mt_regno_i = 0; mt_data_i = 0; mf_regno_i = 0;
        mem_pc_i = 0; irq_i = 0; exc_i = 0; rfe_i = 0; vector_i = 0;
    endtask

    // Drive one cycle: called at negedge; checks outputs from previous edge,
    // applies inputs, checks read path, updates model, waits for next negedge.
    task automatic step(logic mv, logic [4:0] rg, logic [31:0] d, logic [4:0] rr,
                        logic [31:0] pc, logic ir, logic ex, logic rf, logic [31:0] vec);
        logic trap, bw;
        chk("R7 flush", {31'd0, flush_o}, {31'd0, m_flush});
        if (m_flush) chk({m_tag, " restart"}, restart_pc_o, m_restart);
        chk("R2/R4/R8 bank", {24'd0, bank_sel_o}, {24'd0, m_bank});
        mt_valid_i = mv; mt_regno_i = rg; mt_data_i = d; mf_regno_i = rr;
        mem_pc_i = pc; irq_i = ir; exc_i = ex; rfe_i = rf; vector_i = vec;
        #1;
        chk("R9 read", mf_data_o, read_model(rr));
        trap = ir | ex;
        bw   = mv && (rg == 5'd22);
        m_flush = trap | rf | bw;
        if (trap) begin
            m_restart = vec; m_tag = "R4"; m_bank = 8'd0; m_saved = pc;
        end else begin
            if (rf) begin
                m_restart = m_saved; m_tag = "R5";
            end else if (bw) begin
                m_restart = pc + 32'd4; m_tag = "R3";
            end
            if (bw) m_bank = d[7:0];
        end
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        idle();
        rst = 1;
        m_bank = 0; m_saved = 0; m_flush = 0; m_restart = 0; m_tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bank", {24'd0, bank_sel_o}, 32'd0);
        chk("R1 flush", {31'd0, flush_o}, 32'd0);
        chk("R1 restart", restart_pc_o, 32'd0);
        mf_regno_i = 5'd14; #1;
        chk("R1 saved", mf_data_o, 32'd0);
        rst = 0;
        @(negedge clk);

        // Directed: R2/R3 bank write
        step(1, 22, 32'hABCD_0005, 22, 32'h0000_1000, 0, 0, 0, 0);
        step(0, 0, 0, 22, 0, 0, 0, 0, 0);
        // R8: other regno ignored
        step(1, 7, 32'h0000_00FF, 22, 32'h0000_2000, 0, 0, 0, 0);
        step(0, 0, 0, 22, 0, 0, 0, 0, 0);
        // R6: irq with bank write -> vector and bank 0
        step(1, 22, 32'h0000_0009, 22, 32'h0000_3000, 1, 0, 0, 32'h0000_0080);
        step(0, 0, 0, 14, 0, 0, 0, 0, 0);
        // set bank then R6: rfe with bank write -> saved address, bank loaded
        step(1, 22, 32'h0000_0003, 22, 32'h0000_4000, 0, 0, 0, 0);
        step(1, 22, 32'h0000_0011, 22, 32'h0000_5000, 0, 0, 1, 0);
        step(0, 0, 0, 22, 0, 0, 0, 0, 0);
        // R4: exception loses previous bank
        step(0, 0, 0, 22, 32'h0000_6000, 0, 1, 0, 32'h0000_0100);
        step(0, 0, 0, 22, 0, 0, 0, 0, 0);
        // R5: chained traps then return
        step(0, 0, 0, 14, 32'h0000_7000, 1, 0, 0, 32'h0000_0180);
        step(0, 0, 0, 14, 32'h0000_7100, 0, 1, 0, 32'h0000_0100);
        step(0, 0, 0, 14, 0, 0, 0, 1, 0);
        step(0, 0, 0, 14, 0, 0, 0, 0, 0);

        // Random phase
        for (int i = 0; i < 2000; i++) begin
            logic        mv, ir, ex, rf;
            logic [4:0]  rg, rr;
            mv = ($urandom % 3) == 0;
            rg = ($urandom % 2) ? 5'd22 : 5'($urandom);
            rr = ($urandom % 3 == 0) ? 5'd22 : (($urandom % 2) ? 5'd14 : 5'($urandom));
            ir = ($urandom % 8) == 0;
            ex = ($urandom % 10) == 0;
            rf = ($urandom % 7) == 0;
            step(mv, rg, $urandom, rr, {$urandom} & 32'hFFFF_FFFC, ir, ex, rf,
                 {$urandom} & 32'hFFFF_FF00);
        end
        step(0, 0, 0, 22, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule